// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a boundary scan data register placed between a device's core logic and its pins. Each pin owns one or more scan cells according to its kind: input-only pins have one cell on the input path, three-state outputs have one cell on the output path, ordinary bidirectional pins have one cell on each path, open-drain pins have a single data cell and no enable, and the two-wire open-drain pins add an extra control cell of their own. One control cell sets the output enable for a whole group of three-state or bidirectional pins. Analog pins such as the crystal and reset-input pins are not part of the chain.

An external test-port controller supplies the capture, shift and update strobes and a test-mode select. All strobes are sampled on the rising clock edge. Serial data enters at `tdi` and leaves at `tdo`. Position 0 is next to `tdo` and is shifted out first. Every cell has a shift stage and an update latch behind it. The latch only changes on an update strobe, so the pins keep their value while data is shifted. Outside test mode the pins follow the core and the latches have no effect.

The chain order, the kind of every cell and the pin-to-group mapping are parameters. The default configuration has 9 pins, 5 enable groups and 17 cells.

Top module: `bscan_chain`

## Requirements
- R1: After a synchronous active-low reset, every shift stage is 0 and `tdo` is 0. Every update latch is 0, except the open-drain data latches, which are 1. So in test mode right after reset, no pin is driven.
- R2: On a capture strobe, cells load in parallel. Input-path cells and open-drain cells take their pin's `pad_i` bit. Output-path cells take their pin's `core_o` bit. Control cells take their group's `core_grp_oe` bit.
- R3: When the shift strobe is set and capture is not, each clock moves every stage one place toward `tdo`. The top stage takes `tdi`, and `tdo` always shows stage 0.
- R4: If capture and shift are strobed in the same cycle, capture wins and no shift happens.
- R5: On an update strobe, each latch takes the value its shift stage held before that edge, even when shift is strobed in the same cycle. Without an update strobe, the latches hold.
- R6: With `test_mode` low, pins follow the core:
  - three-state and bidirectional pins drive `core_o`, enabled by their group's `core_grp_oe`;
  - open-drain pins drive 0 with enable `~core_o`;
  - two-wire open-drain pins drive 0 with enable `core_grp_oe & ~core_o`;
  - input-only pins have both outputs at 0.
- R7: With `test_mode` high, three-state and bidirectional pins drive their output latch. Each is enabled by the latch of its group's control cell, so one control cell gates every pin in its group.
- R8: With `test_mode` high, an open-drain pin pulls low (`pad_oe`=1, `pad_o`=0) when its data latch is 0 and releases the pin when the latch is 1. A two-wire pin pulls low only when its own control latch is also 1.
- R9: In test mode, capture and shift without an update leave `pad_o` and `pad_oe` unchanged.
- R10: The default chain order, from position 0 (nearest `tdo`) upward, is:
  - 0: control, group 0
  - 1: output, pin 1
  - 2: output, pin 2
  - 3: input, pin 0
  - 4: control, group 1
  - 5: output, pin 3
  - 6: input, pin 3
  - 7: output, pin 4
  - 8: input, pin 4
  - 9: control, group 2
  - 10: output, pin 5
  - 11: input, pin 5
  - 12: open-drain, pin 6
  - 13: control, group 3
  - 14: open-drain, pin 7
  - 15: control, group 4
  - 16: open-drain, pin 8

  Pin kinds and groups:
  - pin 0: input-only
  - pins 1–2: three-state, group 0
  - pins 3–4: bidirectional, group 1
  - pin 5: bidirectional, group 2
  - pin 6: open-drain
  - pins 7 and 8: two-wire open-drain, groups 3 and 4

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tdi | input | 1 | Serial data into the top of the chain |
| capture_en | input | 1 | Parallel capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Latch update strobe |
| test_mode | input | 1 | Pins driven from the latches when high |
| core_o | input | NUM_PINS | Core output data per pin |
| core_grp_oe | input | NUM_GRP | Core output enable per pin group |
| pad_i | input | NUM_PINS | Value seen at each pin |
| pad_o | output | NUM_PINS | Data driven to each pin |
| pad_oe | output | NUM_PINS | Output enable of each pin |
| tdo | output | 1 | Serial data out, chain position 0 |

## Verification
Capture and shift can be strobed in the same cycle, and so can update and shift. Both overlaps are provoked directly after loading a known pattern. Random strobe mixes then raise them again many times. A bench model gives capture priority and makes the update copy the stages as they stood before the edge. `tdo` and every pin output are compared with that model on the falling edge after each step.

// File: rtl/bscan_pkg.sv
// Shared types for the boundary scan chain: cell kinds, pin kinds,
// packed configuration records and the default chain layout.
package bscan_pkg;

    localparam int IDX_W = 6;
    localparam int GRP_W = 5;

    typedef enum logic [1:0] {
        C_IN  = 2'd0,   // input path, captures the pin
        C_OUT = 2'd1,   // output path, captures core data
        C_CTL = 2'd2,   // group enable, captures core enable
        C_OD  = 2'd3    // open-drain data, captures the pin
    } cell_kind_e;

    typedef enum logic [2:0] {
        P_IN    = 3'd0,
        P_TRI   = 3'd1,
        P_BIDIR = 3'd2,
        P_OD    = 3'd3,
        P_ODX   = 3'd4
    } pin_kind_e;

    typedef struct packed {
        cell_kind_e       kind;
        logic [IDX_W-1:0] idx;   // pin index, or group index for C_CTL
    } cell_t;

    typedef struct packed {
        pin_kind_e        kind;
        logic [GRP_W-1:0] grp;
    } pin_t;

    localparam int DEF_LEN  = 17;
    localparam int DEF_PINS = 9;
    localparam int DEF_GRPS = 5;

    // Highest position first; position 0 sits next to tdo.
    localparam cell_t [DEF_LEN-1:0] DEF_CELLS = {
        cell_t'{C_OD,  6'd8},
        cell_t'{C_CTL, 6'd4},
        cell_t'{C_OD,  6'd7},
        cell_t'{C_CTL, 6'd3},
        cell_t'{C_OD,  6'd6},
        cell_t'{C_IN,  6'd5},
        cell_t'{C_OUT, 6'd5},
        cell_t'{C_CTL, 6'd2},
        cell_t'{C_IN,  6'd4},
        cell_t'{C_OUT, 6'd4},
        cell_t'{C_IN,  6'd3},
        cell_t'{C_OUT, 6'd3},
        cell_t'{C_CTL, 6'd1},
        cell_t'{C_IN,  6'd0},
        cell_t'{C_OUT, 6'd2},
        cell_t'{C_OUT, 6'd1},
        cell_t'{C_CTL, 6'd0}
    };

    // Highest pin first.
    localparam pin_t [DEF_PINS-1:0] DEF_PINMAP = {
        pin_t'{P_ODX,   5'd4},
        pin_t'{P_ODX,   5'd3},
        pin_t'{P_OD,    5'd0},
        pin_t'{P_BIDIR, 5'd2},
        pin_t'{P_BIDIR, 5'd1},
        pin_t'{P_BIDIR, 5'd1},
        pin_t'{P_TRI,   5'd0},
        pin_t'{P_TRI,   5'd0},
        pin_t'{P_IN,    5'd0}
    };

endpackage

// File: rtl/bscan_cell.sv
// One scan position: a shift stage and an update latch behind it.
// Assumes the controller never relies on shift when capture is strobed;
// capture takes priority. LATCH_RST sets the latch value after reset.
module bscan_cell #(
    parameter logic LATCH_RST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic capture_en,
    input  logic shift_en,
    input  logic update_en,
    input  logic cap_d,
    input  logic ser_in,
    output logic stage_q,
    output logic latch_q
);

    // Shift stage: parallel capture first, otherwise serial shift.
    always_ff @(posedge clk) begin
        if (!rst_n)          stage_q <= 1'b0;
        else if (capture_en) stage_q <= cap_d;
        else if (shift_en)   stage_q <= ser_in;
    end

    // Update latch: copies the stage only on the update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         latch_q <= LATCH_RST;
        else if (update_en) latch_q <= stage_q;
    end

    // Capture loads the parallel bit, also over a shift (R4).
    assert_capture_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> stage_q == $past(cap_d));

    assert_shift_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !capture_en) |=> stage_q == $past(ser_in));

    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !update_en |=> $stable(latch_q));

    assert_update_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        update_en |=> latch_q == $past(stage_q));

endmodule

// File: rtl/bscan_pad.sv
// Pin output stage for one pin. Selects between the core and the
// scan latches by test_mode and applies the pin kind's drive rule.
// Assumes data_q/ctl_q are tied to some latch even for kinds that ignore them.
module bscan_pad
    import bscan_pkg::*;
#(
    parameter pin_kind_e KIND = P_IN
) (
    input  logic test_mode,
    input  logic core_o,
    input  logic core_oe,
    input  logic data_q,
    input  logic ctl_q,
    output logic pad_o,
    output logic pad_oe
);

    logic unused_inputs;
    assign unused_inputs = ^{test_mode, core_o, core_oe, data_q, ctl_q};

    // Drive rule per pin kind.
    always_comb begin
        pad_o  = 1'b0;
        pad_oe = 1'b0;
        case (KIND)
            P_TRI, P_BIDIR: begin
                pad_o  = test_mode ? data_q : core_o;
                pad_oe = test_mode ? ctl_q  : core_oe;
            end
            P_OD: begin
                pad_oe = test_mode ? ~data_q : ~core_o;
            end
            P_ODX: begin
                pad_oe = test_mode ? (ctl_q & ~data_q) : (core_oe & ~core_o);
            end
            default: begin
                pad_o  = 1'b0;
                pad_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bscan_chain.sv
// Boundary scan data register. Builds the chain from CELL_MAP (position 0
// nearest tdo) and the pin stages from PIN_MAP. Assumes every output or
// open-drain pin has exactly one data cell and every used group one control cell.
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int CHAIN_LEN = DEF_LEN,
    parameter int NUM_PINS  = DEF_PINS,
    parameter int NUM_GRP   = DEF_GRPS,
    parameter cell_t [CHAIN_LEN-1:0] CELL_MAP = DEF_CELLS,
    parameter pin_t  [NUM_PINS-1:0]  PIN_MAP  = DEF_PINMAP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tdi,
    input  logic                capture_en,
    input  logic                shift_en,
    input  logic                update_en,
    input  logic                test_mode,
    input  logic [NUM_PINS-1:0] core_o,
    input  logic [NUM_GRP-1:0]  core_grp_oe,
    input  logic [NUM_PINS-1:0] pad_i,
    output logic [NUM_PINS-1:0] pad_o,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                tdo
);

    localparam int LAST = CHAIN_LEN - 1;

    // Position of the output-side data cell of a pin.
    function automatic int data_pos(int pin);
        for (int i = 0; i < CHAIN_LEN; i++) begin
            if ((CELL_MAP[i].kind == C_OUT || CELL_MAP[i].kind == C_OD) &&
                int'(CELL_MAP[i].idx) == pin)
                return i;
        end
        return 0;
    endfunction

    // Position of the control cell of a group.
    function automatic int ctl_pos(int grp);
        for (int i = 0; i < CHAIN_LEN; i++) begin
            if (CELL_MAP[i].kind == C_CTL && int'(CELL_MAP[i].idx) == grp)
                return i;
        end
        return 0;
    endfunction

    logic [CHAIN_LEN-1:0] stage_q;
    logic [CHAIN_LEN-1:0] latch_q;
    logic                 unused_latch;

    assign tdo          = stage_q[0];
    assign unused_latch = ^latch_q;

    // Chain cells: parallel source and serial neighbour chosen per position.
    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
        localparam cell_t CFG = CELL_MAP[i];
        localparam int    IX  = int'(CFG.idx);
        logic cap_bit;
        logic ser_bit;

        if (CFG.kind == C_CTL) begin : g_ctl
            assign cap_bit = core_grp_oe[IX];
        end else if (CFG.kind == C_OUT) begin : g_out
            assign cap_bit = core_o[IX];
        end else begin : g_pin
            assign cap_bit = pad_i[IX];
        end

        if (i == LAST) begin : g_top
            assign ser_bit = tdi;
        end else begin : g_mid
            assign ser_bit = stage_q[i+1];
        end

        bscan_cell #(
            .LATCH_RST(CFG.kind == C_OD)
        ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .capture_en (capture_en),
            .shift_en   (shift_en),
            .update_en  (update_en),
            .cap_d      (cap_bit),
            .ser_in     (ser_bit),
            .stage_q    (stage_q[i]),
            .latch_q    (latch_q[i])
        );
    end

    // Pin stages: each picks its data latch and its group's control latch.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam pin_t PCFG = PIN_MAP[p];
        localparam int   GIX  = int'(PCFG.grp);
        localparam int   DPOS = data_pos(p);
        localparam int   CPOS = ctl_pos(GIX);

        bscan_pad #(
            .KIND(PCFG.kind)
        ) u_pad (
            .test_mode (test_mode),
            .core_o    (core_o[p]),
            .core_oe   (core_grp_oe[GIX]),
            .data_q    (latch_q[DPOS]),
            .ctl_q     (latch_q[CPOS]),
            .pad_o     (pad_o[p]),
            .pad_oe    (pad_oe[p])
        );
    end

    // Pins stay still in test mode unless an update strobe occurred.
    assert_pins_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && !update_en) |=>
            (!test_mode || ($stable(pad_o) && $stable(pad_oe))));

endmodule

// File: tb/tb_bscan_chain.sv
// Self-checking bench: a bench-side model of the default chain,
// directed corner cases, then seeded random strobe and data mixes.
module tb_bscan_chain;

    localparam int N  = 17;
    localparam int NP = 9;
    localparam int NG = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tdi = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0, tm = 1'b0;
    logic [NP-1:0] core_o = '0, pad_i = '0;
    logic [NG-1:0] grp_oe = '0;
    logic [NP-1:0] pad_o, pad_oe;
    logic tdo;

    always #10 clk = ~clk;

    bscan_chain dut (
        .clk(clk), .rst_n(rst_n), .tdi(tdi), .capture_en(cap), .shift_en(sh),
        .update_en(upd), .test_mode(tm), .core_o(core_o), .core_grp_oe(grp_oe),
        .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .tdo(tdo)
    );

    // R10 layout, as the bench expects it. cell kinds: 0 in, 1 out, 2 ctl, 3 od
    int ckind[N] = '{2,1,1,0,2,1,0,1,0,2,1,0,3,2,3,2,3};
    int cref [N] = '{0,1,2,0,1,3,3,4,4,2,5,5,6,3,7,4,8};
    // pin kinds: 0 in, 1 tri, 2 bidir, 3 od, 4 two-wire od
    int pkind[NP] = '{0,1,1,2,2,2,3,4,4};
    int pgrp [NP] = '{0,0,0,1,1,2,0,3,4};
    int pdat [NP] = '{0,1,2,5,7,10,12,14,16};
    int gctl [NG] = '{0,4,9,13,15};

    logic m_stage[N];
    logic m_latch[N];
    int vecs = 0;
    int bad  = 0;

    task automatic chk(string tag, string what, logic act, logic exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    function automatic logic cap_val(int i);
        case (ckind[i])
            1:       return core_o[cref[i]];
            2:       return grp_oe[cref[i]];
            default: return pad_i[cref[i]];
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_stage[i] = 1'b0;
            m_latch[i] = (ckind[i] == 3);
        end
    endtask

    // One rising edge of the model; update uses the pre-edge stages.
    task automatic model_edge(logic c, logic s, logic u, logic t);
        logic ns[N];
        for (int i = 0; i < N; i++) begin
            if (c)               ns[i] = cap_val(i);
            else if (s && i == N-1) ns[i] = t;
            else if (s)          ns[i] = m_stage[i+1];
            else                 ns[i] = m_stage[i];
        end
        for (int i = 0; i < N; i++) begin
            if (u) m_latch[i] = m_stage[i];
            m_stage[i] = ns[i];
        end
    endtask

    task automatic check_all(string ttag, string ptag);
        chk(ttag, "tdo", tdo, m_stage[0]);
        for (int p = 0; p < NP; p++) begin
            logic eo, eoe, d, g;
            string tag;
            eo = 1'b0; eoe = 1'b0;
            d = m_latch[pdat[p]];
            g = m_latch[gctl[pgrp[p]]];
            case (pkind[p])
                1, 2: begin
                    eo  = tm ? d : core_o[p];
                    eoe = tm ? g : grp_oe[pgrp[p]];
                end
                3: eoe = tm ? ~d : ~core_o[p];
                4: eoe = tm ? (g & ~d) : (grp_oe[pgrp[p]] & ~core_o[p]);
                default: ;
            endcase
            if (ptag != "")                      tag = ptag;
            else if (!tm)                        tag = "R6";
            else if (pkind[p] >= 3)              tag = "R8";
            else                                 tag = "R7";
            chk(tag, $sformatf("pad_o[%0d]", p),  pad_o[p],  eo);
            chk(tag, $sformatf("pad_oe[%0d]", p), pad_oe[p], eoe);
        end
    endtask

    // Called at a falling edge: drive, clock, model, then check.
    task automatic step(logic c, logic s, logic u, logic t, string ttag, string ptag);
        cap = c; sh = s; upd = u; tdi = t;
        @(posedge clk);
        #1 model_edge(c, s, u, t);
        @(negedge clk);
        check_all(ttag, ptag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1149));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1 check_all("R1", "R1");
        tm = 1'b1;
        #1 check_all("R1", "R1");
        // R1: chain empties as zeros
        for (int k = 0; k < N; k++) step(0, 1, 0, 0, "R1", "");

        // R2 / R10: known capture then serial order
        core_o = 9'b101101010; grp_oe = 5'b10110; pad_i = 9'b011001101;
        step(1, 0, 0, 0, "R2", "R9");
        for (int k = 0; k < N; k++) step(0, 1, 0, logic'(k % 2), "R10", "R9");
        step(0, 0, 1, 0, "R5", "");          // R7, R8 on pads

        // R9: shift a new pattern without update
        for (int k = 0; k < N; k++) step(0, 1, 0, logic'($urandom % 2), "R3", "R9");
        step(1, 0, 0, 0, "R2", "R9");

        // R4: capture together with shift
        core_o = 9'b010010101; grp_oe = 5'b01001; pad_i = 9'b100110010;
        step(1, 1, 0, 1, "R4", "R9");
        step(0, 1, 0, 1, "R4", "R9");

        // R5: update in the same cycle as shift
        step(0, 1, 1, 0, "R5", "");
        step(0, 0, 1, 0, "R5", "");

        // R6: normal mode follows the core
        tm = 1'b0;
        for (int k = 0; k < 20; k++) begin
            core_o = NP'($urandom); grp_oe = NG'($urandom); pad_i = NP'($urandom);
            step(0, 0, 0, 0, "R3", "R6");
        end

        // Random mixes
        for (int k = 0; k < 400; k++) begin
            int r;
            r = int'($urandom % 1000);
            core_o = NP'($urandom); grp_oe = NG'($urandom); pad_i = NP'($urandom);
            tm = (($urandom % 4) != 0);
            step(logic'(r % 5 == 0), logic'(r % 3 != 0), logic'(r % 7 == 0),
                 logic'($urandom % 2), "R3", "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule